// File: doc/BRIEF.md
# Byte-Wide Counter Register Interface

This block is the processor-facing front end of a 24-bit counter. A host with an 8-bit data bus, active-low chip select, read and write strobes and a control/data select line writes the counter's configuration registers, loads a 24-bit preset value one byte at a time, reads back a 24-bit snapshot of the counter one byte at a time, and reads a small status byte. The counting logic sits outside this block. It supplies the live count and the status flags, and it receives the configuration registers, the preset value and one-cycle command pulses.

A control write picks its target register from the two top bits of the written byte, so one control address serves four registers. Writes of the preset and reads of the output latch share a single byte pointer that advances after every data access. Master-control writes are commands: each set bit fires once, and no clearing write follows. An active-low load pin, filtered through the same synchroniser, can be set either to load the counter from the preset or to capture the counter into the output latch.

Top module: `ctr_bus_if`

## Requirements
- R1: After reset, dout_en is low, the input, output/counter and quadrature control registers are zero, the preset is 0xFFFFFF and no command pulse is raised.
- R2: A control write (cd_sel=1) picks its target from data bits 7:6: 00 master control, 01 input control (stores bits 5:0), 10 output/counter control (stores bits 5:0), 11 quadrature (stores bits 1:0). The other registers keep their values.
- R3: Data writes (cd_sel=0) fill preset bits 7:0, then 15:8, then 23:16. The shared pointer advances after each one and wraps from byte 2 back to byte 0.
- R4: Data reads return output-latch bits 7:0, 15:8 and 23:16 in that order, with the same advance and wrap. The latch holds its value while the counter moves.
- R5: A status read (cd_sel=1) returns borrow toggle in bit 0, carry toggle in bit 1, compare toggle in bit 2, sign in bit 3, direction in bit 4, and zero in bits 7:5.
- R6: Master-control bits act together in one write. Bit 0 resets the pointer, bit 1 copies cnt_val into the latch, bit 2 pulses cmd_cnt_rst_o, bit 3 pulses cmd_load_o and bit 4 pulses cmd_cmp_clr_o. Each pulse lasts exactly one cycle.
- R7: Master-control bit 5 clears the three control registers, the latch and the pointer, sets the preset to 0xFFFFFF and pulses cmd_mreset_o for one cycle.
- R8: A write or read takes effect once, when the trailing (rising) edge of its strobe is detected, within 3 clock cycles of that edge. Nothing happens while the strobe is held low, and a strobe with cs_n high is ignored.
- R9: dout_en is high only while cs_n and rd_n are both low.
- R10: A falling edge on load_n pulses cmd_load_o when input-control bit 5 is 0, and copies cnt_val into the latch when it is 1.
- R11: The preset writes and the latch reads use one pointer, so a read that follows a write continues at the next byte position.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cs_n | input | 1 | Chip select, active low |
| rd_n | input | 1 | Read strobe, active low |
| wr_n | input | 1 | Write strobe, active low |
| cd_sel | input | 1 | 1 selects control/status, 0 selects preset/latch |
| din | input | 8 | Bus data for writes |
| dout | output | 8 | Bus data for reads |
| dout_en | output | 1 | Bus drive enable |
| load_n | input | 1 | External load pin, active low |
| cnt_val | input | 24 | Live counter value |
| st_borrow_tgl | input | 1 | Borrow toggle flag |
| st_carry_tgl | input | 1 | Carry toggle flag |
| st_cmp_tgl | input | 1 | Compare toggle flag |
| st_sign | input | 1 | Sign flag |
| st_dir | input | 1 | Count direction flag |
| in_ctl_o | output | 6 | Input control register |
| out_ctl_o | output | 6 | Output/counter control register |
| quad_ctl_o | output | 2 | Quadrature mode register |
| preset_o | output | 24 | Preset register |
| cmd_cnt_rst_o | output | 1 | Counter reset pulse |
| cmd_load_o | output | 1 | Load counter from preset pulse |
| cmd_cmp_clr_o | output | 1 | Compare toggle clear pulse |
| cmd_mreset_o | output | 1 | Master reset pulse |

## Verification
A strobe released between two clock edges passes two synchroniser flops. Register, pointer and latch updates land on the third rising edge after the release, and command pulses rise on that same edge. The bench therefore waits four clock cycles after each release before it samples, and it holds chip select, control/data and data steady over that window. Read data and dout_en are combinational from the bus pins, so they are sampled at a falling edge two cycles into the strobe. Command pulses are counted every cycle and their longest run is recorded, so an extra or stretched pulse shows up in the counts.

// File: rtl/ctr_bus_pkg.sv
// Package ctr_bus_pkg
// Shared encodings for the counter register interface: control register
// select codes carried in the top data bits and master-control bit positions.
package ctr_bus_pkg;

    // Control register chosen by data bits [7:6] of a control write
    typedef enum logic [1:0] {
        SEL_MASTER = 2'b00,
        SEL_INPUT  = 2'b01,
        SEL_OUTCNT = 2'b10,
        SEL_QUAD   = 2'b11
    } ctl_sel_e;

    // Master-control command bit positions
    localparam int MC_PTR_RST = 0;
    localparam int MC_LATCH   = 1;
    localparam int MC_CNT_RST = 2;
    localparam int MC_LOAD    = 3;
    localparam int MC_CMP_CLR = 4;
    localparam int MC_MRESET  = 5;

    // Input control bit choosing the load-pin role (0: load counter, 1: latch)
    localparam int IC_PIN_LATCH = 5;

    // Decoded master-control command set
    typedef struct packed {
        logic ptr_rst;
        logic latch;
        logic cnt_rst;
        logic load;
        logic cmp_clr;
        logic mreset;
    } mc_cmd_t;

endpackage

// File: rtl/edge_sync.sv
// Module edge_sync
// Synchronises an asynchronous active-low strobe or pin to clk and flags one
// edge as a single-cycle pulse. RISE=1 flags the trailing (rising) edge,
// RISE=0 the falling edge. Assumes the input idles high; the chain resets high.
module edge_sync #(
    parameter int STAGES = 2,
    parameter bit RISE   = 1'b1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic async_i,
    output logic edge_o
);
    logic [STAGES:0] sh;
    logic            now_s;
    logic            prev_s;

    // Shift the input through the synchroniser plus one history flop
    always_ff @(posedge clk) begin
        if (!rst_n) sh <= '1;
        else        sh <= {sh[STAGES-1:0], async_i};
    end

    assign now_s  = sh[STAGES-1];
    assign prev_s = sh[STAGES];

    generate
        if (RISE) begin : g_rise
            assign edge_o = now_s & ~prev_s;
        end else begin : g_fall
            assign edge_o = ~now_s & prev_s;
        end
    endgenerate

    AST_SINGLE_EDGE: assert property (@(posedge clk) disable iff (!rst_n)
        edge_o |=> !edge_o); // R8

endmodule

// File: rtl/byte_ptr.sv
// Module byte_ptr
// Shared byte pointer for multi-byte preset and latch access. Clear wins over
// advance; advance wraps from the last byte back to byte 0.
module byte_ptr #(
    parameter  int NBYTES = 3,
    localparam int PW     = (NBYTES > 1) ? $clog2(NBYTES) : 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clr_i,
    input  logic          adv_i,
    output logic [PW-1:0] ptr_o
);
    localparam logic [PW-1:0] LAST = PW'(NBYTES - 1);

    // Hold, clear or advance the pointer with wrap-around
    always_ff @(posedge clk) begin
        if (!rst_n)      ptr_o <= '0;
        else if (clr_i)  ptr_o <= '0;
        else if (adv_i)  ptr_o <= (ptr_o == LAST) ? '0 : ptr_o + 1'b1;
    end

    AST_PTR_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        ptr_o <= LAST); // R3
    AST_PTR_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
        (adv_i && !clr_i && ptr_o == LAST) |=> ptr_o == '0); // R3
    AST_PTR_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        clr_i |=> ptr_o == '0); // R6

endmodule

// File: rtl/ctl_regs.sv
// Module ctl_regs
// Control register file and preset register. Decodes the target of a control
// write from the top data bits, turns master-control writes into immediate
// command strobes plus registered one-cycle pulses, and stores preset bytes at
// the pointer position. Assumes ctl_wr_i / dat_wr_i are single-cycle events.
module ctl_regs
    import ctr_bus_pkg::*;
#(
    parameter  int DW     = 8,
    parameter  int CW     = 6,
    parameter  int QW     = 2,
    parameter  int NBYTES = 3,
    localparam int PW     = (NBYTES > 1) ? $clog2(NBYTES) : 1,
    localparam int PRW    = DW * NBYTES
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           ctl_wr_i,
    input  logic           dat_wr_i,
    input  logic [DW-1:0]  din_i,
    input  logic [PW-1:0]  ptr_i,
    output logic           ptr_clr_o,
    output logic           latch_now_o,
    output logic           mreset_now_o,
    output logic           cnt_rst_o,
    output logic           load_o,
    output logic           cmp_clr_o,
    output logic           mreset_o,
    output logic [CW-1:0]  in_ctl_o,
    output logic [CW-1:0]  out_ctl_o,
    output logic [QW-1:0]  quad_ctl_o,
    output logic [PRW-1:0] preset_o
);
    ctl_sel_e sel;
    mc_cmd_t  mc_now;

    assign sel = ctl_sel_e'(din_i[DW-1:DW-2]);

    // Decode a master-control write into this cycle's command set
    always_comb begin
        mc_now = '0;
        if (ctl_wr_i && sel == SEL_MASTER) begin
            mc_now.ptr_rst = din_i[MC_PTR_RST];
            mc_now.latch   = din_i[MC_LATCH];
            mc_now.cnt_rst = din_i[MC_CNT_RST];
            mc_now.load    = din_i[MC_LOAD];
            mc_now.cmp_clr = din_i[MC_CMP_CLR];
            mc_now.mreset  = din_i[MC_MRESET];
        end
    end

    assign ptr_clr_o    = mc_now.ptr_rst | mc_now.mreset;
    assign latch_now_o  = mc_now.latch;
    assign mreset_now_o = mc_now.mreset;

    // Register the counter-side commands as one-cycle pulses
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_rst_o <= 1'b0;
            load_o    <= 1'b0;
            cmp_clr_o <= 1'b0;
            mreset_o  <= 1'b0;
        end else begin
            cnt_rst_o <= mc_now.cnt_rst;
            load_o    <= mc_now.load;
            cmp_clr_o <= mc_now.cmp_clr;
            mreset_o  <= mc_now.mreset;
        end
    end

    // Update control registers and preset bytes; master reset restores defaults
    always_ff @(posedge clk) begin
        if (!rst_n || mc_now.mreset) begin
            in_ctl_o   <= '0;
            out_ctl_o  <= '0;
            quad_ctl_o <= '0;
            preset_o   <= '1;
        end else begin
            if (ctl_wr_i) begin
                case (sel)
                    SEL_INPUT:  in_ctl_o   <= din_i[CW-1:0];
                    SEL_OUTCNT: out_ctl_o  <= din_i[CW-1:0];
                    SEL_QUAD:   quad_ctl_o <= din_i[QW-1:0];
                    default:    ;
                endcase
            end
            if (dat_wr_i) begin
                for (int b = 0; b < NBYTES; b++) begin
                    if (ptr_i == PW'(b)) preset_o[b*DW +: DW] <= din_i;
                end
            end
        end
    end

    AST_CMD_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt_rst_o || load_o || cmp_clr_o || mreset_o)
        |=> !(cnt_rst_o || load_o || cmp_clr_o || mreset_o)); // R6
    AST_CTL_TARGET: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_wr_i && sel != SEL_INPUT && !mc_now.mreset) |=> $stable(in_ctl_o)); // R2

endmodule

// File: rtl/ctr_bus_if.sv
// Module ctr_bus_if
// Top of the byte-wide register interface for a 24-bit counter. Synchronises
// the bus strobes and load pin, acts on trailing strobe edges, keeps the output
// latch and shared byte pointer, and muxes latch bytes or status onto dout.
// Assumes cs_n, cd_sel and din are steady from strobe low until three clocks
// after the strobe rises.
module ctr_bus_if
    import ctr_bus_pkg::*;
#(
    parameter  int DW     = 8,
    parameter  int NBYTES = 3,
    parameter  int CW     = 6,
    parameter  int QW     = 2,
    parameter  int STAGES = 2,
    localparam int CNTW   = DW * NBYTES,
    localparam int PW     = (NBYTES > 1) ? $clog2(NBYTES) : 1
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            cs_n,
    input  logic            rd_n,
    input  logic            wr_n,
    input  logic            cd_sel,
    input  logic [DW-1:0]   din,
    output logic [DW-1:0]   dout,
    output logic            dout_en,
    input  logic            load_n,
    input  logic [CNTW-1:0] cnt_val,
    input  logic            st_borrow_tgl,
    input  logic            st_carry_tgl,
    input  logic            st_cmp_tgl,
    input  logic            st_sign,
    input  logic            st_dir,
    output logic [CW-1:0]   in_ctl_o,
    output logic [CW-1:0]   out_ctl_o,
    output logic [QW-1:0]   quad_ctl_o,
    output logic [CNTW-1:0] preset_o,
    output logic            cmd_cnt_rst_o,
    output logic            cmd_load_o,
    output logic            cmd_cmp_clr_o,
    output logic            cmd_mreset_o
);
    logic            wr_rise, rd_rise, pin_fall;
    logic            ctl_wr, dat_wr, dat_rd;
    logic            ptr_clr, latch_now, mreset_now;
    logic            bus_load;
    logic            pin_load_q;
    logic            pin_latch;
    logic [PW-1:0]   ptr;
    logic [CNTW-1:0] latch_q;
    logic [DW-1:0]   latch_byte;
    logic [DW-1:0]   status_byte;

    edge_sync #(.STAGES(STAGES), .RISE(1'b1)) u_wr_sync (
        .clk(clk), .rst_n(rst_n), .async_i(wr_n), .edge_o(wr_rise));
    edge_sync #(.STAGES(STAGES), .RISE(1'b1)) u_rd_sync (
        .clk(clk), .rst_n(rst_n), .async_i(rd_n), .edge_o(rd_rise));
    edge_sync #(.STAGES(STAGES), .RISE(1'b0)) u_pin_sync (
        .clk(clk), .rst_n(rst_n), .async_i(load_n), .edge_o(pin_fall));

    // Qualify strobe edges with chip select and the control/data line
    assign ctl_wr = wr_rise & ~cs_n &  cd_sel;
    assign dat_wr = wr_rise & ~cs_n & ~cd_sel;
    assign dat_rd = rd_rise & ~cs_n & ~cd_sel;

    ctl_regs #(.DW(DW), .CW(CW), .QW(QW), .NBYTES(NBYTES)) u_regs (
        .clk(clk), .rst_n(rst_n),
        .ctl_wr_i(ctl_wr), .dat_wr_i(dat_wr), .din_i(din), .ptr_i(ptr),
        .ptr_clr_o(ptr_clr), .latch_now_o(latch_now), .mreset_now_o(mreset_now),
        .cnt_rst_o(cmd_cnt_rst_o), .load_o(bus_load), .cmp_clr_o(cmd_cmp_clr_o),
        .mreset_o(cmd_mreset_o),
        .in_ctl_o(in_ctl_o), .out_ctl_o(out_ctl_o), .quad_ctl_o(quad_ctl_o),
        .preset_o(preset_o));

    byte_ptr #(.NBYTES(NBYTES)) u_ptr (
        .clk(clk), .rst_n(rst_n), .clr_i(ptr_clr), .adv_i(dat_wr | dat_rd),
        .ptr_o(ptr));

    assign pin_latch = pin_fall & in_ctl_o[IC_PIN_LATCH];

    // Register the pin-driven load so it aligns with bus-driven load pulses
    always_ff @(posedge clk) begin
        if (!rst_n) pin_load_q <= 1'b0;
        else        pin_load_q <= pin_fall & ~in_ctl_o[IC_PIN_LATCH];
    end

    assign cmd_load_o = bus_load | pin_load_q;

    // Output latch: cleared by master reset, loaded from the live count
    always_ff @(posedge clk) begin
        if (!rst_n || mreset_now)          latch_q <= '0;
        else if (latch_now || pin_latch)   latch_q <= cnt_val;
    end

    // Select the latch byte addressed by the pointer
    always_comb begin
        latch_byte = '0;
        for (int b = 0; b < NBYTES; b++) begin
            if (ptr == PW'(b)) latch_byte = latch_q[b*DW +: DW];
        end
    end

    assign status_byte = {{(DW-5){1'b0}}, st_dir, st_sign, st_cmp_tgl,
                          st_carry_tgl, st_borrow_tgl};
    assign dout        = cd_sel ? status_byte : latch_byte;
    assign dout_en     = ~cs_n & ~rd_n;

    AST_MRESET_STATE: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_mreset_o |-> (preset_o == '1 && in_ctl_o == '0 &&
                          out_ctl_o == '0 && quad_ctl_o == '0)); // R7
    AST_LATCH_CAPTURE: assert property (@(posedge clk) disable iff (!rst_n)
        (latch_now && !mreset_now) |=> latch_q == $past(cnt_val)); // R6
    AST_NO_WRITE_UNSELECTED: assert property (@(posedge clk) disable iff (!rst_n)
        (cs_n && !mreset_now) |=> $stable(preset_o)); // R8

endmodule

// File: tb/sim_ctr_bus_if.sv
// Directed bench for ctr_bus_if: one task per scenario, each checking itself.
module sim_ctr_bus_if;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cs_n = 1'b1, rd_n = 1'b1, wr_n = 1'b1, cd_sel = 1'b0;
    logic [7:0]  din = '0;
    logic [7:0]  dout;
    logic        dout_en;
    logic        load_n = 1'b1;
    logic [23:0] cnt_val = '0;
    logic        st_b = 0, st_c = 0, st_m = 0, st_s = 0, st_d = 0;
    logic [5:0]  in_ctl, out_ctl;
    logic [1:0]  quad_ctl;
    logic [23:0] preset;
    logic        p_cnt_rst, p_load, p_cmp_clr, p_mreset;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    always #2 clk = ~clk;

    ctr_bus_if u0 (
        .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .rd_n(rd_n), .wr_n(wr_n),
        .cd_sel(cd_sel), .din(din), .dout(dout), .dout_en(dout_en),
        .load_n(load_n), .cnt_val(cnt_val),
        .st_borrow_tgl(st_b), .st_carry_tgl(st_c), .st_cmp_tgl(st_m),
        .st_sign(st_s), .st_dir(st_d),
        .in_ctl_o(in_ctl), .out_ctl_o(out_ctl), .quad_ctl_o(quad_ctl),
        .preset_o(preset),
        .cmd_cnt_rst_o(p_cnt_rst), .cmd_load_o(p_load),
        .cmd_cmp_clr_o(p_cmp_clr), .cmd_mreset_o(p_mreset));

    // Pulse counters and longest-run tracking: 0 cnt_rst, 1 load, 2 cmp_clr, 3 mreset
    int pcnt[4];
    int prun[4];
    int pmax[4];
    always @(posedge clk) begin
        logic [3:0] pv;
        pv = {p_mreset, p_cmp_clr, p_load, p_cnt_rst};
        for (int i = 0; i < 4; i++) begin
            if (rst_n && pv[i]) begin
                pcnt[i] = pcnt[i] + 1;
                prun[i] = prun[i] + 1;
                if (prun[i] > pmax[i]) pmax[i] = prun[i];
            end else begin
                prun[i] = 0;
            end
        end
    end

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    endtask

    // Bus write: strobe held low for 'hold' cycles, then 4 cycles for the effect
    task automatic bus_wr(input logic cd, input logic [7:0] d, input int hold, input logic sel_n);
        @(negedge clk);
        cs_n = sel_n; cd_sel = cd; din = d; wr_n = 1'b0;
        repeat (hold) @(negedge clk);
        wr_n = 1'b1;
        repeat (4) @(negedge clk);
        cs_n = 1'b1;
    endtask

    // Bus read: sample dout and dout_en two cycles into the strobe
    task automatic bus_rd(input logic cd, output logic [7:0] d, output logic en);
        @(negedge clk);
        cs_n = 1'b0; cd_sel = cd; rd_n = 1'b0;
        repeat (2) @(negedge clk);
        d = dout; en = dout_en;
        rd_n = 1'b1;
        repeat (4) @(negedge clk);
        cs_n = 1'b1;
    endtask

    task automatic pin_pulse();
        @(negedge clk);
        load_n = 1'b0;
        repeat (3) @(negedge clk);
        load_n = 1'b1;
        repeat (4) @(negedge clk);
    endtask

    task automatic t_reset();
        check("R1 dout_en", {31'b0, dout_en}, 0);
        check("R1 in_ctl", {26'b0, in_ctl}, 0);
        check("R1 out_ctl", {26'b0, out_ctl}, 0);
        check("R1 quad_ctl", {30'b0, quad_ctl}, 0);
        check("R1 preset", {8'b0, preset}, 32'hFFFFFF);
        check("R1 pulses", pcnt[0] + pcnt[1] + pcnt[2] + pcnt[3], 0);
    endtask

    task automatic t_ctl_writes();
        bus_wr(1'b1, 8'h40 | 8'h2A, 2, 1'b0);
        check("R2 input ctl", {26'b0, in_ctl}, 32'h2A);
        bus_wr(1'b1, 8'h80 | 8'h15, 2, 1'b0);
        check("R2 outcnt ctl", {26'b0, out_ctl}, 32'h15);
        check("R2 input kept", {26'b0, in_ctl}, 32'h2A);
        bus_wr(1'b1, 8'hC3, 2, 1'b0);
        check("R2 quad ctl", {30'b0, quad_ctl}, 3);
        check("R2 outcnt kept", {26'b0, out_ctl}, 32'h15);
    endtask

    task automatic t_strobe_rules();
        // Long strobe: no change while low, one change after release
        @(negedge clk);
        cs_n = 1'b0; cd_sel = 1'b1; din = 8'h40 | 8'h11; wr_n = 1'b0;
        repeat (10) @(negedge clk);
        check("R8 held strobe", {26'b0, in_ctl}, 32'h2A);
        wr_n = 1'b1;
        repeat (4) @(negedge clk);
        cs_n = 1'b1;
        check("R8 trailing edge", {26'b0, in_ctl}, 32'h11);
        // Chip select high: write ignored
        bus_wr(1'b1, 8'h40 | 8'h3F, 2, 1'b1);
        check("R8 cs high ignored", {26'b0, in_ctl}, 32'h11);
        bus_wr(1'b0, 8'hEE, 2, 1'b1);
        check("R8 cs high preset", {8'b0, preset}, 32'hFFFFFF);
    endtask

    task automatic t_preset();
        bus_wr(1'b1, 8'h01, 2, 1'b0);
        bus_wr(1'b0, 8'h12, 2, 1'b0);
        bus_wr(1'b0, 8'h34, 2, 1'b0);
        bus_wr(1'b0, 8'h56, 2, 1'b0);
        check("R3 preset order", {8'b0, preset}, 32'h563412);
        bus_wr(1'b0, 8'h9A, 2, 1'b0);
        check("R3 pointer wrap", {8'b0, preset}, 32'h56349A);
    endtask

    task automatic t_latch_read();
        logic [7:0] d;
        logic en;
        cnt_val = 24'hABCDEF;
        bus_wr(1'b1, 8'h03, 2, 1'b0);
        bus_rd(1'b0, d, en);
        check("R4 byte0", {24'b0, d}, 32'hEF);
        check("R9 dout_en during read", {31'b0, en}, 1);
        bus_rd(1'b0, d, en);
        check("R4 byte1", {24'b0, d}, 32'hCD);
        bus_rd(1'b0, d, en);
        check("R4 byte2", {24'b0, d}, 32'hAB);
        cnt_val = 24'h000777;
        bus_rd(1'b0, d, en);
        check("R4 wrap and hold", {24'b0, d}, 32'hEF);
        check("R9 dout_en idle", {31'b0, dout_en}, 0);
        @(negedge clk);
        rd_n = 1'b0;
        @(negedge clk);
        check("R9 cs high no drive", {31'b0, dout_en}, 0);
        rd_n = 1'b1;
        repeat (4) @(negedge clk);
    endtask

    task automatic t_status();
        logic [7:0] d;
        logic en;
        {st_d, st_s, st_m, st_c, st_b} = 5'b10110;
        bus_rd(1'b1, d, en);
        check("R5 status a", {24'b0, d}, 32'h16);
        {st_d, st_s, st_m, st_c, st_b} = 5'b01001;
        bus_rd(1'b1, d, en);
        check("R5 status b", {24'b0, d}, 32'h09);
        {st_d, st_s, st_m, st_c, st_b} = 5'b11111;
        bus_rd(1'b1, d, en);
        check("R5 upper bits zero", {24'b0, d}, 32'h1F);
    endtask

    task automatic t_cmds();
        int c0, c1, c2, c3;
        c0 = pcnt[0]; c1 = pcnt[1]; c2 = pcnt[2]; c3 = pcnt[3];
        bus_wr(1'b1, 8'h1C, 2, 1'b0);
        repeat (6) @(negedge clk);
        check("R6 cnt_rst once", pcnt[0] - c0, 1);
        check("R6 load once", pcnt[1] - c1, 1);
        check("R6 cmp_clr once", pcnt[2] - c2, 1);
        check("R6 no mreset", pcnt[3] - c3, 0);
        check("R6 pulse width", pmax[0] + pmax[1] + pmax[2], 3);
        check("R6 regs untouched", {26'b0, in_ctl}, 32'h11);
    endtask

    task automatic t_shared_ptr();
        logic [7:0] d;
        logic en;
        bus_wr(1'b1, 8'h01, 2, 1'b0);
        bus_wr(1'b0, 8'h77, 2, 1'b0);
        check("R11 write at byte0", {8'b0, preset}, 32'h563477);
        bus_rd(1'b0, d, en);
        check("R11 read continues at byte1", {24'b0, d}, 32'hCD);
    endtask

    task automatic t_pin();
        logic [7:0] d;
        logic en;
        int c1;
        c1 = pcnt[1];
        pin_pulse();
        check("R10 pin loads counter", pcnt[1] - c1, 1);
        bus_wr(1'b1, 8'h60, 2, 1'b0);
        cnt_val = 24'h123456;
        c1 = pcnt[1];
        pin_pulse();
        check("R10 latch mode no load", pcnt[1] - c1, 0);
        bus_wr(1'b1, 8'h01, 2, 1'b0);
        bus_rd(1'b0, d, en);
        check("R10 pin latched count", {24'b0, d}, 32'h56);
    endtask

    task automatic t_mreset();
        logic [7:0] d;
        logic en;
        int c3;
        c3 = pcnt[3];
        bus_rd(1'b0, d, en);  // move pointer off byte 0
        bus_wr(1'b1, 8'h20, 2, 1'b0);
        repeat (2) @(negedge clk);
        check("R7 mreset pulse", pcnt[3] - c3, 1);
        check("R7 preset ones", {8'b0, preset}, 32'hFFFFFF);
        check("R7 ctl cleared", {20'b0, in_ctl, out_ctl}, 0);
        check("R7 quad cleared", {30'b0, quad_ctl}, 0);
        bus_rd(1'b0, d, en);
        check("R7 latch and ptr cleared", {24'b0, d}, 0);
    endtask

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_ctl_writes();
        t_strobe_rules();
        t_preset();
        t_latch_read();
        t_status();
        t_cmds();
        t_shared_ptr();
        t_pin();
        t_mreset();
        done = 1;
        finish_run();
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            finish_run();
        end
    end

endmodule